// File: doc/BRIEF.md
# Register-Move Instruction Byte Decoder

This block decodes the 16-bit register/memory move opcode family from a serial stream of instruction bytes, taking one byte in each cycle in which `byteValid` is high. Idle cycles between bytes are allowed. Before the opcode it may take an operand-size override byte (66H) and an address-size override byte (67H), in either order. It then splits the opcode byte and the addressing byte into their fields and collects the displacement bytes that the mode field asks for.

When the last byte of an instruction has been taken, the block presents one decoded record. The record holds the direction and width bits, the mode, register and r/m codes, a register-operand flag, a 16-bit displacement, the two override flags and the total instruction length in bytes, counting prefixes. A byte that cannot start or continue an instruction raises a one-cycle error pulse and returns the decoder to its starting state.

Top module: `movDecode`

## Requirements
- R1: After reset `recValid` and `errPulse` are low, no override flag is pending, and the decoder expects a prefix or opcode byte.
- R2: An opcode byte with bits 7:2 equal to 100010 is accepted (values 88H to 8BH). Its bit 1 is reported as `recDir` and its bit 0 as `recWide` (0 = byte, 1 = word).
- R3: The byte after the opcode is split into mode (bits 7:6), register (bits 5:3) and r/m (bits 2:0). `recIsReg` is 1 exactly when the mode is 11.
- R4: For mode 11, and for mode 00 with r/m other than 110, no displacement byte follows. `recDisp` is 0000H and the length is 2 plus the number of prefixes.
- R5: For mode 01 one displacement byte follows. It is sign-extended: 00H to 7FH gives 0000H to 007FH, and 80H to FFH gives FF80H to FFFFH.
- R6: For mode 10, and for mode 00 with r/m 110, two displacement bytes follow, low byte first. The length is 4 plus the number of prefixes.
- R7: A leading 66H sets `recOpSize` and a leading 67H sets `recAddrSize`, each counted as one byte of length. The flags apply only to the instruction that follows and are clear in the record of the next instruction.
- R8: In the prefix/opcode position, any byte that is neither a supported opcode nor a first occurrence of a prefix pulses `errPulse` for one cycle. It discards pending prefixes and returns the decoder to its starting state. A repeated identical prefix counts as such an error.
- R9: `recValid` is high for exactly one cycle, in the cycle after the clock edge that takes the last byte of an instruction. Cycles with `byteValid` low neither advance nor disturb decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Instruction byte present this cycle |
| byteIn | input | 8 | Instruction byte |
| recValid | output | 1 | One-cycle pulse: decoded record valid |
| recDir | output | 1 | Direction bit of the opcode |
| recWide | output | 1 | Width bit of the opcode |
| recMode | output | 2 | Mode field |
| recReg | output | 3 | Register field |
| recRm | output | 3 | R/M field |
| recIsReg | output | 1 | R/M names a register (mode 11) |
| recDisp | output | 16 | Sign-extended or full 16-bit displacement |
| recOpSize | output | 1 | Operand-size override seen |
| recAddrSize | output | 1 | Address-size override seen |
| recLen | output | LEN_W | Instruction length in bytes, prefixes included |
| errPulse | output | 1 | One-cycle pulse: unsupported byte |

## Verification
The main sweep drives every opcode in the family with all 256 addressing bytes under each of the four prefix combinations, with idle gaps mixed in. This separates the three displacement lengths, and it separates the direct-address case from ordinary mode 00. The displacement bytes are chosen so that the low byte takes both signs, which shows sign extension apart from zero extension. A second sweep puts every byte value in the opcode position and follows each error with a clean instruction, which shows whether stale prefixes survive. The known encodings 8B EC, 8A 15 and 8A 55 01 and a repeated prefix are tried as fixed cases.

// File: rtl/movDecodePkg.sv
package movDecodePkg;
  localparam logic [5:0] OPC_MOVRM  = 6'b100010;
  localparam logic [7:0] PFX_OPSIZE = 8'h66;
  localparam logic [7:0] PFX_ADSIZE = 8'h67;
  localparam logic [1:0] MODE_NONE  = 2'b00;
  localparam logic [1:0] MODE_D8    = 2'b01;
  localparam logic [1:0] MODE_D16   = 2'b10;
  localparam logic [1:0] MODE_REG   = 2'b11;
  localparam logic [2:0] RM_DIRECT  = 3'b110;

  typedef enum logic [1:0] {ST_LEAD, ST_MODRM, ST_DISPLO, ST_DISPHI} stateT;

  typedef struct packed {
    logic setOp;
    logic setAd;
    logic loadOpc;
    logic loadModrm;
    logic loadLo;
    logic loadHi;
    logic emit;
    logic fail;
  } strobeT;
endpackage

// File: rtl/movDecodeCtrl.sv
module movDecodeCtrl
  import movDecodePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  input  logic       opSeen,
  input  logic       adSeen,
  output strobeT     stb
);
  stateT state, stateNext;
  logic  needTwo, needTwoNext;

  always_comb begin
    stb         = '0;
    stateNext   = state;
    needTwoNext = needTwo;
    if (byteValid) begin
      unique case (state)
        ST_LEAD: begin
          if (byteIn == PFX_OPSIZE) begin
            if (opSeen) stb.fail = 1'b1;
            else        stb.setOp = 1'b1;
          end else if (byteIn == PFX_ADSIZE) begin
            if (adSeen) stb.fail = 1'b1;
            else        stb.setAd = 1'b1;
          end else if (byteIn[7:2] == OPC_MOVRM) begin
            stb.loadOpc = 1'b1;
            stateNext   = ST_MODRM;
          end else begin
            stb.fail = 1'b1;
          end
        end
        ST_MODRM: begin
          stb.loadModrm = 1'b1;
          if (byteIn[7:6] == MODE_D8) begin
            needTwoNext = 1'b0;
            stateNext   = ST_DISPLO;
          end else if (byteIn[7:6] == MODE_D16 ||
                       (byteIn[7:6] == MODE_NONE && byteIn[2:0] == RM_DIRECT)) begin
            needTwoNext = 1'b1;
            stateNext   = ST_DISPLO;
          end else begin
            stb.emit  = 1'b1;
            stateNext = ST_LEAD;
          end
        end
        ST_DISPLO: begin
          stb.loadLo = 1'b1;
          if (needTwo) begin
            stateNext = ST_DISPHI;
          end else begin
            stb.emit  = 1'b1;
            stateNext = ST_LEAD;
          end
        end
        ST_DISPHI: begin
          stb.loadHi = 1'b1;
          stb.emit   = 1'b1;
          stateNext  = ST_LEAD;
        end
        default: stateNext = ST_LEAD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_LEAD;
      needTwo <= 1'b0;
    end else begin
      state   <= stateNext;
      needTwo <= needTwoNext;
    end
  end

  // R6: the high displacement byte is only reached through the low one
  a_r6_hi_after_lo: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DISPHI) |-> ($past(state) == ST_DISPLO || $past(state) == ST_DISPHI));
  // R9: the state is held across idle cycles
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |=> $stable(state));
endmodule

// File: rtl/movDecodeDatapath.sv
module movDecodeDatapath
  import movDecodePkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       byteIn,
  input  strobeT           stb,
  output logic             opSeen,
  output logic             adSeen,
  output logic             recValid,
  output logic             recDir,
  output logic             recWide,
  output logic [1:0]       recMode,
  output logic [2:0]       recReg,
  output logic [2:0]       recRm,
  output logic             recIsReg,
  output logic [15:0]      recDisp,
  output logic             recOpSize,
  output logic             recAddrSize,
  output logic [LEN_W-1:0] recLen,
  output logic             errPulse
);
  localparam int DISP_W = 16;
  localparam int HALF_W = DISP_W / 2;

  logic [1:0]       dwReg;
  logic [7:0]       modrmReg, loReg;
  logic [LEN_W-1:0] lenReg;
  logic [7:0]       modrmCur, loCur;
  logic [DISP_W-1:0] dispCur;
  logic             consume;

  assign consume  = stb.setOp | stb.setAd | stb.loadOpc | stb.loadModrm | stb.loadLo | stb.loadHi;
  assign modrmCur = stb.loadModrm ? byteIn : modrmReg;
  assign loCur    = stb.loadLo ? byteIn : loReg;

  always_comb begin
    unique case (modrmCur[7:6])
      MODE_D8:   dispCur = {{HALF_W{loCur[7]}}, loCur};
      MODE_D16:  dispCur = {byteIn, loReg};
      MODE_NONE: dispCur = (modrmCur[2:0] == RM_DIRECT) ? {byteIn, loReg} : '0;
      default:   dispCur = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opSeen <= 1'b0; adSeen <= 1'b0; dwReg <= '0;
      modrmReg <= '0; loReg <= '0; lenReg <= '0;
      recValid <= 1'b0; errPulse <= 1'b0;
      recDir <= 1'b0; recWide <= 1'b0; recMode <= '0; recReg <= '0; recRm <= '0;
      recIsReg <= 1'b0; recDisp <= '0; recOpSize <= 1'b0; recAddrSize <= 1'b0; recLen <= '0;
    end else begin
      recValid <= stb.emit;
      errPulse <= stb.fail;
      if (stb.setOp)     opSeen   <= 1'b1;
      if (stb.setAd)     adSeen   <= 1'b1;
      if (stb.loadOpc)   dwReg    <= byteIn[1:0];
      if (stb.loadModrm) modrmReg <= byteIn;
      if (stb.loadLo)    loReg    <= byteIn;
      if (consume)       lenReg   <= lenReg + 1'b1;
      if (stb.emit) begin
        recDir      <= dwReg[1];
        recWide     <= dwReg[0];
        recMode     <= modrmCur[7:6];
        recReg      <= modrmCur[5:3];
        recRm       <= modrmCur[2:0];
        recIsReg    <= (modrmCur[7:6] == MODE_REG);
        recDisp     <= dispCur;
        recOpSize   <= opSeen;
        recAddrSize <= adSeen;
        recLen      <= lenReg + 1'b1;
      end
      if (stb.emit || stb.fail) begin
        opSeen <= 1'b0;
        adSeen <= 1'b0;
        lenReg <= '0;
      end
    end
  end

  // R5: a one-byte displacement arrives sign-extended
  a_r5_sign_extend: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && recMode == MODE_D8) |-> (recDisp[15:8] == {8{recDisp[7]}}));
  // R4: register mode carries no displacement and is flagged as register
  a_r4_reg_nodisp: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && recMode == MODE_REG) |-> (recDisp == '0 && recIsReg));
  // R7: the length counts the prefixes reported in the record
  a_r7_len_prefix: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && recMode == MODE_D8) |-> (recLen == LEN_W'(3 + recOpSize + recAddrSize)));
  // R9: the record pulse never lasts two cycles
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    recValid |=> !recValid);
  // R8: error and record never coincide
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(recValid && errPulse));
endmodule

// File: rtl/movDecode.sv
module movDecode
  import movDecodePkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic [7:0]       byteIn,
  output logic             recValid,
  output logic             recDir,
  output logic             recWide,
  output logic [1:0]       recMode,
  output logic [2:0]       recReg,
  output logic [2:0]       recRm,
  output logic             recIsReg,
  output logic [15:0]      recDisp,
  output logic             recOpSize,
  output logic             recAddrSize,
  output logic [LEN_W-1:0] recLen,
  output logic             errPulse
);
  strobeT stb;
  logic   opSeen, adSeen;

  movDecodeCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .opSeen(opSeen), .adSeen(adSeen), .stb(stb)
  );

  movDecodeDatapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .byteIn(byteIn), .stb(stb),
    .opSeen(opSeen), .adSeen(adSeen),
    .recValid(recValid), .recDir(recDir), .recWide(recWide), .recMode(recMode),
    .recReg(recReg), .recRm(recRm), .recIsReg(recIsReg), .recDisp(recDisp),
    .recOpSize(recOpSize), .recAddrSize(recAddrSize), .recLen(recLen),
    .errPulse(errPulse)
  );
endmodule

// File: tb/movDecode_tb.sv
module movDecode_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteIn = '0;
  logic        recValid, recDir, recWide, recIsReg, recOpSize, recAddrSize, errPulse;
  logic [1:0]  recMode;
  logic [2:0]  recReg, recRm;
  logic [15:0] recDisp;
  logic [3:0]  recLen;

  int checks = 0;
  int errors = 0;
  logic sawValid, sawErr, early;

  always #10 clk = ~clk;

  movDecode u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .recValid(recValid), .recDir(recDir), .recWide(recWide), .recMode(recMode),
    .recReg(recReg), .recRm(recRm), .recIsReg(recIsReg), .recDisp(recDisp),
    .recOpSize(recOpSize), .recAddrSize(recAddrSize), .recLen(recLen),
    .errPulse(errPulse)
  );

  task automatic sendByte(input logic [7:0] b);
    byteValid = 1'b1;
    byteIn    = b;
    @(negedge clk);
    sawValid  = recValid;
    sawErr    = errPulse;
    byteValid = 1'b0;
  endtask

  task automatic idle();
    byteValid = 1'b0;
    @(negedge clk);
    if (recValid || errPulse) early = 1'b1;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Sends one instruction; pfx bit0 = 66H, bit1 = 67H, swap picks order.
  task automatic runInstr(input logic [1:0] pfx, input logic swap, input logic [7:0] opc,
                          input logic [7:0] modrm, input logic [7:0] lo, input logic [7:0] hi,
                          input logic gap);
    int nd;
    logic [15:0] expDisp;
    logic [3:0]  expLen;
    logic [1:0]  md;
    md = modrm[7:6];
    if (md == 2'b01) nd = 1;
    else if (md == 2'b10 || (md == 2'b00 && modrm[2:0] == 3'b110)) nd = 2;
    else nd = 0;
    expDisp = (nd == 1) ? {{8{lo[7]}}, lo} : (nd == 2) ? {hi, lo} : 16'h0000;
    expLen  = 4'(2 + nd + pfx[0] + pfx[1]);
    early = 1'b0;
    if (swap) begin
      if (pfx[1]) begin sendByte(8'h67); early |= sawValid | sawErr; end
      if (pfx[0]) begin sendByte(8'h66); early |= sawValid | sawErr; end
    end else begin
      if (pfx[0]) begin sendByte(8'h66); early |= sawValid | sawErr; end
      if (pfx[1]) begin sendByte(8'h67); early |= sawValid | sawErr; end
    end
    if (gap) idle();
    sendByte(opc);
    early |= sawValid | sawErr;
    if (gap) idle();
    if (nd == 0) sendByte(modrm);
    else begin
      sendByte(modrm); early |= sawValid | sawErr;
      if (nd == 1) sendByte(lo);
      else begin
        if (gap) idle();
        sendByte(lo); early |= sawValid | sawErr;
        sendByte(hi);
      end
    end
    // R9 pulse after last byte only; R2 R3 R4 R5 R6 R7 fields
    check("R9", {early, sawValid, sawErr}, {1'b0, 1'b1, 1'b0});
    check("R2", {recDir, recWide}, opc[1:0]);
    check("R3", {recMode, recReg, recRm, recIsReg}, {modrm, md == 2'b11});
    check(nd == 1 ? "R5" : nd == 2 ? "R6" : "R4", {recDisp, recLen}, {expDisp, expLen});
    check("R7", {recOpSize, recAddrSize}, {pfx[0], pfx[1]});
    @(negedge clk);
    check("R9", recValid, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", {recValid, errPulse}, 2'b00);
    runInstr(2'b00, 1'b0, 8'h8B, 8'hEC, 8'h00, 8'h00, 1'b0);
    check("R1", {recOpSize, recAddrSize, recLen}, {2'b00, 4'd2});
    // fixed encodings
    runInstr(2'b00, 1'b0, 8'h8A, 8'h15, 8'h00, 8'h00, 1'b0);
    runInstr(2'b00, 1'b0, 8'h8A, 8'h55, 8'h01, 8'h00, 1'b0);
    check("R5", recDisp, 16'h0001);
    runInstr(2'b00, 1'b0, 8'h8A, 8'h55, 8'h80, 8'h00, 1'b0);
    check("R5", recDisp, 16'hFF80);
    // R7: prefixes apply only to the next instruction
    runInstr(2'b11, 1'b0, 8'h89, 8'hC0, 8'h00, 8'h00, 1'b0);
    runInstr(2'b00, 1'b0, 8'h89, 8'hC0, 8'h00, 8'h00, 1'b0);
    // R8: repeated prefix
    sendByte(8'h66); sendByte(8'h66);
    check("R8", {sawValid, sawErr}, 2'b01);
    @(negedge clk);
    check("R8", errPulse, 1'b0);
    runInstr(2'b00, 1'b0, 8'h8B, 8'hEC, 8'h00, 8'h00, 1'b0);
    // main sweep
    for (int p = 0; p < 4; p++) begin
      for (int o = 0; o < 4; o++) begin
        for (int m = 0; m < 256; m++) begin
          runInstr(2'(p), 1'(o), 8'h88 + 8'(o), 8'(m), 8'(m * 7 + p), 8'(m ^ 8'hA5), 1'((m % 5) == 0));
        end
      end
    end
    // R8: every byte in the opcode position
    for (int b = 0; b < 256; b++) begin
      logic [7:0] v;
      v = 8'(b);
      if (v == 8'h66 || v == 8'h67 || v[7:2] == 6'b100010) continue;
      sendByte(8'h66);
      sendByte(v);
      check("R8", {sawValid, sawErr}, 2'b01);
      runInstr(2'b00, 1'b0, 8'h88, 8'h01, 8'h00, 8'h00, 1'b0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule